// File: doc/BRIEF.md
# Interrupt Acceptance and Enable Control

This block sits beside the sequencer of an 8-bit CPU core and decides, at every point where an interrupt may be taken, whether one is taken and which kind. It owns the two interrupt enable flip-flops (the live enable and its saved copy) and the 2-bit interrupt mode register. It holds a falling edge seen on the non-maskable input and watches the maskable input as a level. When a request is accepted it emits a one-cycle pulse that carries the request kind and the current mode. The sequencer uses that pulse to start its own bus cycles, and those bus cycles are outside this block.

The sequencer marks the legal sample points with two strobes. The first marks the end of an ordinary instruction. The second marks the end of one pass of a block-repeat instruction, or one internal no-op while halted. The decoder drives one-cycle strobes for enable, disable, mode load and return-from-non-maskable. It also raises a flag while an instruction that copies the saved enable into the parity/overflow flag is running. If such an instruction is interrupted, the block asks for that flag to be cleared. All pins are plain control signals and have no handshake.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While `rst_n` is low, and just after it rises, both enable flip-flops and the mode are 0, `iff2_out` is 0, and no accept pulse is issued.
- R2: A request is accepted only in a cycle where `insn_end` or `iter_end` is high at the clock edge. The accept outputs show the result in the cycle after that edge.
- R3: A maskable request is accepted when `int_n` is low at a sample point, the live enable is set, and no enable-delay window is open. It is reported with `take_kind` = 1.
- R4: A high-to-low transition of `nmi_n` is held as a pending request until it is accepted. Holding `nmi_n` low does not raise another request. It is reported with `take_kind` = 0.
- R5: When a pending non-maskable request and an active maskable request meet at one sample point, the non-maskable one is taken. The maskable one stays pending and can be accepted later if it is still active and re-enabled.
- R6: Every acceptance clears the live enable. The saved copy (`iff2_out`) is cleared only when the maskable request is accepted, and it is left unchanged when the non-maskable request is accepted.
- R7: If an enable strobe arrives while the live enable is clear, no maskable request is accepted at the sample point that ends that enable instruction. The earliest acceptance is at the end of the instruction after it.
- R8: A disable strobe clears both flip-flops. An enable strobe sets both. A return-from-non-maskable strobe copies the saved copy into the live enable. An acceptance in the same cycle overrides all of these strobes.
- R9: `im_stb` loads `im_sel` into the mode register. `take_mode` shows the mode that was in force at the accepting sample point.
- R10: `pv_clear` pulses together with the accept pulse when `ldair_active` was high at the accepting sample point, and it stays low otherwise.
- R11: `take_pulse` is high for exactly one cycle per accepted sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | Sample point: end of an instruction |
| iter_end | input | 1 | Sample point: end of one repeat pass or halt no-op |
| int_n | input | 1 | Maskable request, active low, level sensed |
| nmi_n | input | 1 | Non-maskable request, falling edge sensed |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| im_stb | input | 1 | Mode-load instruction strobe |
| im_sel | input | 2 | Mode value to load |
| retn_stb | input | 1 | Return-from-non-maskable strobe |
| ldair_active | input | 1 | Instruction copying saved enable into P/V is executing |
| take_pulse | output | 1 | One-cycle acceptance pulse |
| take_kind | output | 1 | 0 = non-maskable, 1 = maskable |
| take_mode | output | 2 | Mode in force at acceptance |
| iff2_out | output | 1 | Saved enable flip-flop |
| pv_clear | output | 1 | Request to force the P/V result to 0 |

## Verification
The bench presents the maskable level with and without the enables set. It gives a falling edge on the non-maskable pin alone, then keeps that pin held low, which separates edge sensing from level sensing. Both requests are raised together to check priority and that the maskable request is kept. The enable strobe is tested once alone and once ahead of the sample point, which shows whether the delay window exists or the enable merely takes effect late. Both sample strobes, mode values 1 and 2, and the P/V flag both high and low are run against acceptances of each kind. These runs show that the kind, the mode and the clear request belong to the right event.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [0:0] {
    KIND_NMI  = 1'b0,
    KIND_MASK = 1'b1
  } irq_kind_t;

  typedef logic [MODE_W-1:0] irq_mode_t;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic consume,
  output logic pending
);
  logic nmi_q;
  logic fall;

  assign fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q   <= 1'b1;
      pending <= 1'b0;
    end else begin
      nmi_q   <= nmi_n;
      pending <= fall | (pending & ~consume);
    end
  end

  // R4: a new pending request is only ever caused by a low pin level
  a_r4_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> !$past(nmi_n));
  // R4: a held request is cleared only by consumption
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(consume));
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sample,
  input  logic      acc_any,
  input  logic      acc_int,
  input  logic      ei_stb,
  input  logic      di_stb,
  input  logic      retn_stb,
  input  logic      im_stb,
  input  irq_mode_t im_sel,
  output logic      iff1,
  output logic      iff2,
  output logic      ei_shadow,
  output irq_mode_t mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (acc_any) begin
      iff1 <= 1'b0;
      if (acc_int) iff2 <= 1'b0;
    end else if (di_stb) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (ei_stb) begin
      iff1 <= 1'b1;
      iff2 <= 1'b1;
    end else if (retn_stb) begin
      iff1 <= iff2;
    end
  end

  // delay window: enable seen before its own sample point while disabled
  always_ff @(posedge clk) begin
    if (!rst_n)                        ei_shadow <= 1'b0;
    else if (sample)                   ei_shadow <= 1'b0;
    else if (ei_stb && !iff1)          ei_shadow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mode <= '0;
    else if (im_stb) mode <= im_sel;
  end

  // R6: any acceptance leaves the live enable clear
  a_r6_iff1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |=> !iff1);
  // R6: maskable acceptance clears the saved copy as well
  a_r6_iff2_int: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int |=> !iff2);
  // R6: non-maskable acceptance keeps the saved copy
  a_r6_iff2_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_any && !acc_int) |=> iff2 == $past(iff2));
  // R8: disable without acceptance clears both
  a_r8_di: assert property (@(posedge clk) disable iff (!rst_n)
    (di_stb && !acc_any) |=> (!iff1 && !iff2));
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_end,
  input  logic       iter_end,
  input  logic       int_n,
  input  logic       nmi_n,
  input  logic       ei_stb,
  input  logic       di_stb,
  input  logic       im_stb,
  input  logic [1:0] im_sel,
  input  logic       retn_stb,
  input  logic       ldair_active,
  output logic       take_pulse,
  output logic       take_kind,
  output logic [1:0] take_mode,
  output logic       iff2_out,
  output logic       pv_clear
);
  logic      sample;
  logic      nmi_pend;
  logic      acc_nmi, acc_int, acc_any;
  logic      iff1, iff2, ei_shadow;
  irq_mode_t mode;
  irq_kind_t kind_d;

  assign sample  = insn_end | iter_end;
  assign acc_nmi = sample & nmi_pend;
  assign acc_int = sample & ~nmi_pend & ~int_n & iff1 & ~ei_shadow;
  assign acc_any = acc_nmi | acc_int;
  assign kind_d  = acc_int ? KIND_MASK : KIND_NMI;

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_n   (nmi_n),
    .consume (acc_nmi),
    .pending (nmi_pend)
  );

  irq_enable_regs u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (sample),
    .acc_any   (acc_any),
    .acc_int   (acc_int),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .retn_stb  (retn_stb),
    .im_stb    (im_stb),
    .im_sel    (im_sel),
    .iff1      (iff1),
    .iff2      (iff2),
    .ei_shadow (ei_shadow),
    .mode      (mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_pulse <= 1'b0;
      take_kind  <= 1'b0;
      take_mode  <= '0;
      pv_clear   <= 1'b0;
    end else begin
      take_pulse <= acc_any;
      take_kind  <= kind_d;
      take_mode  <= mode;
      pv_clear   <= acc_any & ldair_active;
    end
  end

  assign iff2_out = iff2;

  // R2: pulses only follow a sample point
  a_r2_sample_only: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> $past(insn_end || iter_end));
  // R3/R7: maskable acceptance needs enable and a closed delay window
  a_r7_shadow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pulse && take_kind) |-> ($past(iff1) && !$past(ei_shadow) && !$past(int_n)));
  // R5: non-maskable wins whenever it was pending
  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && nmi_pend) |=> (take_pulse && !take_kind));
  // R10: clear request only alongside an acceptance
  a_r10_pv_with_take: assert property (@(posedge clk) disable iff (!rst_n)
    pv_clear |-> take_pulse);
endmodule

// File: tb/sim_irq_accept_ctrl.sv
`timescale 1ns/1ps
module sim_irq_accept_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_end = 0, iter_end = 0, int_n = 1, nmi_n = 1;
  logic ei_stb = 0, di_stb = 0, im_stb = 0, retn_stb = 0, ldair_active = 0;
  logic [1:0] im_sel = 2'd0;
  logic take_pulse, take_kind, iff2_out, pv_clear;
  logic [1:0] take_mode;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_accept_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .iter_end(iter_end),
    .int_n(int_n), .nmi_n(nmi_n), .ei_stb(ei_stb), .di_stb(di_stb),
    .im_stb(im_stb), .im_sel(im_sel), .retn_stb(retn_stb),
    .ldair_active(ldair_active), .take_pulse(take_pulse),
    .take_kind(take_kind), .take_mode(take_mode), .iff2_out(iff2_out),
    .pv_clear(pv_clear)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ck_eq(input string tag, input int act, input int exp);
    ck(act == exp, tag, act, exp);
  endtask

  // one instruction-end sample point
  task automatic end_insn();
    insn_end = 1; step(); insn_end = 0;
  endtask

  // enable strobe at its own sample point (no window left open)
  task automatic enable_now();
    ei_stb = 1; insn_end = 1; step(); ei_stb = 0; insn_end = 0;
  endtask

  task automatic t_reset();
    ck_eq("R1 take_pulse at reset", take_pulse, 0);
    ck_eq("R1 iff2_out at reset", iff2_out, 0);
    rst_n = 1; step();
    int_n = 0; end_insn();
    ck_eq("R1 no accept while disabled after reset", take_pulse, 0);
    int_n = 1;
  endtask

  task automatic t_ei_delay();
    int_n = 0;
    ei_stb = 1; step(); ei_stb = 0;
    end_insn();
    ck_eq("R7 no accept at end of enable instruction", take_pulse, 0);
    ck_eq("R8 enable sets saved copy", iff2_out, 1);
    end_insn();
    ck_eq("R3 maskable accepted after next instruction", take_pulse, 1);
    ck_eq("R11 kind code 1 for maskable", take_kind, 1);
    ck_eq("R9 mode 0 after reset", take_mode, 0);
    ck_eq("R6 saved copy cleared on maskable", iff2_out, 0);
    step();
    ck_eq("R11 pulse lasts one cycle", take_pulse, 0);
    int_n = 1;
  endtask

  task automatic t_sample_points();
    int_n = 1; enable_now();
    int_n = 0;
    step(); step(); step();
    ck_eq("R2 no accept without sample strobe", take_pulse, 0);
    iter_end = 1; step(); iter_end = 0;
    ck_eq("R2 accept at repeat-iteration strobe", take_pulse, 1);
    int_n = 1; step();
  endtask

  task automatic t_nmi_edge();
    enable_now();
    nmi_n = 0; step();
    end_insn();
    ck_eq("R4 falling edge accepted", take_pulse, 1);
    ck_eq("R4 kind code 0 for non-maskable", take_kind, 0);
    ck_eq("R6 saved copy kept on non-maskable", iff2_out, 1);
    end_insn();
    ck_eq("R4 held low does not retrigger", take_pulse, 0);
    nmi_n = 1; step();
    retn_stb = 1; step(); retn_stb = 0;
  endtask

  task automatic t_nmi_prio();
    enable_now();
    nmi_n = 0; step();
    int_n = 0; end_insn();
    ck(take_pulse && !take_kind, "R5 non-maskable wins", int'(take_kind), 0);
    end_insn();
    ck_eq("R6 live enable cleared after non-maskable", take_pulse, 0);
    retn_stb = 1; step(); retn_stb = 0;
    end_insn();
    ck(take_pulse && take_kind, "R5 maskable still pending after return", int'(take_pulse), 1);
    ck_eq("R8 return restored live enable", take_kind, 1);
    int_n = 1; nmi_n = 1; step();
  endtask

  task automatic t_di();
    enable_now();
    di_stb = 1; step(); di_stb = 0;
    ck_eq("R8 disable clears saved copy", iff2_out, 0);
    int_n = 0; end_insn();
    ck_eq("R8 disable blocks maskable", take_pulse, 0);
    int_n = 1;
  endtask

  task automatic t_mode();
    im_sel = 2'd2; im_stb = 1; step(); im_stb = 0;
    enable_now();
    int_n = 0; end_insn();
    ck_eq("R9 mode 2 shown with accept", take_mode, 2);
    int_n = 1;
    im_sel = 2'd1; im_stb = 1; step(); im_stb = 0;
    nmi_n = 0; step();
    end_insn();
    ck_eq("R9 mode 1 shown with accept", take_mode, 1);
    nmi_n = 1; step();
  endtask

  task automatic t_pv();
    enable_now();
    int_n = 0; ldair_active = 1; end_insn(); ldair_active = 0;
    ck(take_pulse && pv_clear, "R10 pv clear on interrupted copy", int'(pv_clear), 1);
    int_n = 1;
    nmi_n = 0; step();
    end_insn();
    ck(take_pulse && !pv_clear, "R10 no pv clear otherwise", int'(pv_clear), 0);
    nmi_n = 1; step();
  endtask

  initial begin
    step(); step();
    t_reset();
    t_ei_delay();
    t_sample_points();
    t_nmi_edge();
    t_nmi_prio();
    t_di();
    t_mode();
    t_pv();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule